// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

After a synchronous reset this block walks the 32 management addresses and asks each one for its status register through a single-outstanding management access port (request/done handshake). Addresses whose status word looks like a real transceiver are logged into a small table, up to `PHY_SLOTS` entries. The walk begins at address 1, runs up to 31 and ends at address 0. It ends as soon as the table is full.

For every transceiver it logs, the sequencer also reads the control and advertisement registers. It picks an advertisement value and writes it back only when needed. It then computes a new control word. In auto mode that word turns autonegotiation on. In forced mode it turns autonegotiation off and applies the requested speed and duplex. Once the walk is over, the table, the number of entries found and a sticky done flag are presented at the outputs.

Top module: `phy_disc_seq`

## Requirements
- R1: The status register (register 1) is read at addresses 1, 2, …, 31 and then 0, in that order. The walk ends right after the transceiver that fills entry `PHY_SLOTS-1` has been handled, and no further address is read after that.
- R2: An address is accepted when (status & 0x8301) == 0x8001, or when status bit 9 is 0 and (status & 0x7800) != 0. Any other status word is skipped, and no other register at that address is accessed.
- R3: Accepted addresses are stored in acceptance order. Entry i sits at `phy_table[5*i+4:5*i]`, and `phy_count` is the number of entries stored.
- R4: If no address is accepted, `phy_count` is 0 and entry 0 holds address 1. All other entries are 0.
- R5: If the advertisement value read (register 4) has bits 8..5 all zero, the effective value becomes ((status >> 6) & 0x03E0) | 1. Otherwise the effective value is the value read.
- R6: A nonzero `cfg_adv` replaces the effective value. Register 4 is written with the chosen value only when that value differs from the effective value.
- R7: In auto mode (`cfg_forced`=0) the new control word has bit 12 set. If bit 12 was 0 in the value read, bit 9 is set as well.
- R8: In forced mode (`cfg_forced`=1) the new control word has bit 12 cleared.
- R9: The new control word always has bits 15, 14, 11, 10 and 7 cleared. Bit 8 is set to `cfg_full_duplex` and bit 13 is set to `cfg_speed100`. All other bits are carried over from the value read.
- R10: Register 0 is written only when the new word differs from the value read. If bit 12 changed, the same word is written twice, and at least `GAP_CYCLES` clocks pass between the done of the first write and the request of the second.
- R11: `mdio_req` stays high with stable command fields until `mdio_done` is seen. Once `scan_done` is set it stays set, and no further requests are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the scan begins when it is released |
| cfg_forced | input | 1 | 1 = forced media (autonegotiation off), 0 = auto |
| cfg_full_duplex | input | 1 | Value placed in control bit 8 |
| cfg_speed100 | input | 1 | Value placed in control bit 13 |
| cfg_adv | input | 16 | Configured advertisement; 0 means "use the derived value" |
| mdio_req | output | 1 | Management access request |
| mdio_write | output | 1 | 1 = write access, 0 = read access |
| mdio_phy | output | 5 | Transceiver address of the access |
| mdio_reg | output | 5 | Register index of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion pulse from the management master |
| mdio_rdata | input | 16 | Read data, valid while `mdio_done` is high |
| phy_table | output | 5*PHY_SLOTS | Table of found addresses, entry i at bits 5*i+4:5*i |
| phy_count | output | clog2(PHY_SLOTS+1) | Number of table entries found |
| scan_done | output | 1 | Sticky flag set when the scan has finished |

## Verification
The assertions assume that `mdio_done` pulses for exactly one cycle, only while `mdio_req` is high, and at most once per request. They also assume that the four configuration inputs stay constant from the release of reset until `scan_done`. The bench's transceiver model waits for a request, holds off for a fixed latency and then returns one done pulse together with the register contents. The configuration is changed only while reset is held, so each scan runs against a fixed set of inputs.

// File: rtl/phy_disc_pkg.sv
package phy_disc_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;

    // control bits that never survive reconfiguration
    localparam logic [DATA_W-1:0] CTRL_DROP_MASK = 16'hED80;
    localparam int CTRL_AN_EN   = 12;
    localparam int CTRL_AN_RST  = 9;
    localparam int CTRL_DUPLEX  = 8;
    localparam int CTRL_SPD100  = 13;

    typedef enum logic [3:0] {
        ST_STAT,
        ST_CTRL_RD,
        ST_ADV_RD,
        ST_DECIDE,
        ST_ADV_WR,
        ST_CTRL_WR1,
        ST_GAP,
        ST_CTRL_WR2,
        ST_NEXT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] regsel;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              an_toggled;
    } ctrl_plan_t;

    function automatic logic status_looks_valid(input logic [DATA_W-1:0] s);
        return ((s & 16'h8301) == 16'h8001) ||
               (!s[9] && ((s & 16'h7800) != 16'h0000));
    endfunction

    function automatic logic [DATA_W-1:0] adv_effective(input logic [DATA_W-1:0] adv,
                                                       input logic [DATA_W-1:0] stat);
        if (adv[8:5] == 4'b0000)
            return ((stat >> 6) & 16'h03E0) | 16'h0001;
        return adv;
    endfunction

    function automatic ctrl_plan_t ctrl_compute(input logic [DATA_W-1:0] cur,
                                                input logic forced,
                                                input logic fdx,
                                                input logic spd);
        ctrl_plan_t p;
        p.value      = cur;
        p.an_toggled = 1'b0;
        if (!forced) begin
            p.value[CTRL_AN_EN] = 1'b1;
            if (!cur[CTRL_AN_EN]) begin
                p.value[CTRL_AN_RST] = 1'b1;
                p.an_toggled         = 1'b1;
            end
        end else begin
            p.value[CTRL_AN_EN] = 1'b0;
            p.an_toggled        = cur[CTRL_AN_EN];
        end
        p.value              = p.value & ~CTRL_DROP_MASK;
        p.value[CTRL_DUPLEX] = fdx;
        p.value[CTRL_SPD100] = spd;
        return p;
    endfunction

endpackage

// File: rtl/pds_gap_timer.sv
module pds_gap_timer #(
    parameter int GAP_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int TW = $clog2(GAP_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= TW'(GAP_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R10: a freshly started gap never reports expiry on the next cycle
    assert_gap_not_short_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> !expired);

endmodule

// File: rtl/pds_table.sv
module pds_table #(
    parameter int SLOTS  = 4,
    parameter int AW     = 5,
    parameter int CW     = 3,
    parameter logic [AW-1:0] DEFAULT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_idx,
    input  logic [AW-1:0]     wr_addr,
    input  logic              fill_default,
    output logic [SLOTS*AW-1:0] table_o
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [AW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && (wr_idx == CW'(i)))
                slot_q <= wr_addr;
            else if (fill_default && (i == 0))
                slot_q <= DEFAULT_ADDR;
        end
        assign table_o[i*AW +: AW] = slot_q;
    end

    // R3: entries are only written inside the table
    assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < SLOTS));

endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import phy_disc_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_forced,
    input  logic              cfg_full_duplex,
    input  logic              cfg_speed100,
    input  logic [DATA_W-1:0] cfg_adv,
    output logic              req,
    output mgmt_cmd_t         cmd,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic              tbl_we,
    output logic [CW-1:0]     count,
    output logic              fill_default,
    output logic              gap_start,
    input  logic              gap_expired,
    output logic              finished
);
    localparam logic [CW-1:0] FULL = CW'(SLOTS);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     count_q;
    logic [DATA_W-1:0] stat_q, ctrl_q, adv_q;
    logic              req_q, done_q;

    logic              is_access, xfer, last_visit;
    logic [DATA_W-1:0] adv_eff, adv_pick;
    ctrl_plan_t        plan;
    seq_state_e        after_adv;

    assign adv_eff  = adv_effective(adv_q, stat_q);
    assign adv_pick = (cfg_adv != '0) ? cfg_adv : adv_eff;
    assign plan     = ctrl_compute(ctrl_q, cfg_forced, cfg_full_duplex, cfg_speed100);
    assign after_adv = (plan.value != ctrl_q) ? ST_CTRL_WR1 : ST_NEXT;

    always_comb begin
        cmd       = '{wr: 1'b0, regsel: REG_STAT, wdata: '0};
        is_access = 1'b1;
        unique case (state_q)
            ST_STAT:     cmd.regsel = REG_STAT;
            ST_CTRL_RD:  cmd.regsel = REG_CTRL;
            ST_ADV_RD:   cmd.regsel = REG_ADV;
            ST_ADV_WR:   cmd = '{wr: 1'b1, regsel: REG_ADV, wdata: adv_pick};
            ST_CTRL_WR1,
            ST_CTRL_WR2: cmd = '{wr: 1'b1, regsel: REG_CTRL, wdata: plan.value};
            default:     is_access = 1'b0;
        endcase
    end

    assign xfer         = req_q && done;
    assign last_visit   = (count_q == FULL) || (addr_q == '0);
    assign tbl_we       = (state_q == ST_STAT) && xfer && status_looks_valid(rdata);
    assign gap_start    = (state_q == ST_CTRL_WR1) && xfer && plan.an_toggled;
    assign fill_default = (state_q == ST_NEXT) && last_visit && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STAT;
            addr_q  <= 5'd1;
            count_q <= '0;
            stat_q  <= '0;
            ctrl_q  <= '0;
            adv_q   <= '0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            req_q <= is_access && !xfer;
            unique case (state_q)
                ST_STAT: if (xfer) begin
                    stat_q <= rdata;
                    if (status_looks_valid(rdata)) begin
                        count_q <= count_q + 1'b1;
                        state_q <= ST_CTRL_RD;
                    end else begin
                        state_q <= ST_NEXT;
                    end
                end
                ST_CTRL_RD: if (xfer) begin
                    ctrl_q  <= rdata;
                    state_q <= ST_ADV_RD;
                end
                ST_ADV_RD: if (xfer) begin
                    adv_q   <= rdata;
                    state_q <= ST_DECIDE;
                end
                ST_DECIDE:   state_q <= (adv_pick != adv_eff) ? ST_ADV_WR : after_adv;
                ST_ADV_WR:   if (xfer) state_q <= after_adv;
                ST_CTRL_WR1: if (xfer) state_q <= plan.an_toggled ? ST_GAP : ST_NEXT;
                ST_GAP:      if (gap_expired) state_q <= ST_CTRL_WR2;
                ST_CTRL_WR2: if (xfer) state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (last_visit) begin
                        state_q <= ST_FINISH;
                        done_q  <= 1'b1;
                    end else begin
                        addr_q  <= addr_q + 1'b1;
                        state_q <= ST_STAT;
                    end
                end
                default: state_q <= ST_FINISH;
            endcase
        end
    end

    assign req      = req_q;
    assign cur_addr = addr_q;
    assign count    = count_q;
    assign finished = done_q;

    // R11: a pending request keeps its command until completion
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (req && !done) |=> (req && $stable(cmd) && $stable(cur_addr)));

    // R11: finished is sticky and silent
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        finished |=> (finished && !req));

    // R1: never more entries than slots
    assert_count_cap_R1: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= SLOTS);

    // R6: writes only ever target the advertisement or control register
    assert_write_target_R6: assert property (@(posedge clk) disable iff (rst)
        (req && cmd.wr) |-> (cmd.regsel == REG_CTRL || cmd.regsel == REG_ADV));

    // R10: a control write always changes the register
    assert_ctrl_write_changes_R10: assert property (@(posedge clk) disable iff (rst)
        (req && cmd.wr && cmd.regsel == REG_CTRL) |-> (cmd.wdata != ctrl_q));

endmodule

// File: rtl/phy_disc_seq.sv
module phy_disc_seq
    import phy_disc_pkg::*;
#(
    parameter int PHY_SLOTS  = 4,
    parameter int GAP_CYCLES = 500
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_forced,
    input  logic                              cfg_full_duplex,
    input  logic                              cfg_speed100,
    input  logic [15:0]                       cfg_adv,
    output logic                              mdio_req,
    output logic                              mdio_write,
    output logic [4:0]                        mdio_phy,
    output logic [4:0]                        mdio_reg,
    output logic [15:0]                       mdio_wdata,
    input  logic                              mdio_done,
    input  logic [15:0]                       mdio_rdata,
    output logic [PHY_SLOTS*5-1:0]            phy_table,
    output logic [$clog2(PHY_SLOTS+1)-1:0]    phy_count,
    output logic                              scan_done
);
    localparam int CW = $clog2(PHY_SLOTS + 1);

    mgmt_cmd_t         cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic              tbl_we, fill_default, gap_start, gap_expired;
    logic [CW-1:0]     count;

    pds_seq #(.SLOTS(PHY_SLOTS), .CW(CW)) seq_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_forced     (cfg_forced),
        .cfg_full_duplex(cfg_full_duplex),
        .cfg_speed100   (cfg_speed100),
        .cfg_adv        (cfg_adv),
        .req            (mdio_req),
        .cmd            (cmd),
        .cur_addr       (cur_addr),
        .done           (mdio_done),
        .rdata          (mdio_rdata),
        .tbl_we         (tbl_we),
        .count          (count),
        .fill_default   (fill_default),
        .gap_start      (gap_start),
        .gap_expired    (gap_expired),
        .finished       (scan_done)
    );

    pds_table #(.SLOTS(PHY_SLOTS), .AW(ADDR_W), .CW(CW), .DEFAULT_ADDR(5'd1)) table_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (tbl_we),
        .wr_idx      (count),
        .wr_addr     (cur_addr),
        .fill_default(fill_default),
        .table_o     (phy_table)
    );

    pds_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
        .clk    (clk),
        .rst    (rst),
        .start  (gap_start),
        .expired(gap_expired)
    );

    assign mdio_write = cmd.wr;
    assign mdio_phy   = cur_addr;
    assign mdio_reg   = cmd.regsel;
    assign mdio_wdata = cmd.wdata;
    assign phy_count  = count;

endmodule

// File: tb/phy_disc_seq_tb.sv
module phy_disc_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 4;
    localparam int GAP        = 40;
    localparam int LAT        = 2;
    localparam int LOGMAX     = 160;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_forced = 1'b0, cfg_full_duplex = 1'b0, cfg_speed100 = 1'b0;
    logic [15:0] cfg_adv = '0;
    logic mdio_req, mdio_write, mdio_done;
    logic [4:0] mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata;
    logic [SLOTS*5-1:0] phy_table;
    logic [$clog2(SLOTS+1)-1:0] phy_count;
    logic scan_done;

    phy_disc_seq #(.PHY_SLOTS(SLOTS), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_forced(cfg_forced), .cfg_full_duplex(cfg_full_duplex),
        .cfg_speed100(cfg_speed100), .cfg_adv(cfg_adv),
        .mdio_req(mdio_req), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
        .mdio_rdata(mdio_rdata), .phy_table(phy_table), .phy_count(phy_count),
        .scan_done(scan_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0, n_bad = 0;

    // transceiver register model
    logic [15:0] st [32];
    logic [15:0] ct [32];
    logic [15:0] ad [32];

    // observed transaction log
    int lg_n;
    int lg_key [LOGMAX];
    int lg_phy [LOGMAX];
    int lg_reg [LOGMAX];
    int lg_treq [LOGMAX];
    int lg_tdone [LOGMAX];

    // expected transaction list
    int ex_n;
    int ex_key [LOGMAX];
    int ex_tab [SLOTS];
    int ex_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // responder for the management port
    initial begin
        mdio_done  = 1'b0;
        mdio_rdata = '0;
        lg_n       = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                lg_n = 0;
                mdio_done = 1'b0;
            end else if (mdio_req) begin
                int p, r, idx;
                p = int'(mdio_phy);
                r = int'(mdio_reg);
                idx = lg_n;
                if (idx < LOGMAX) begin
                    lg_key[idx]  = {int'(mdio_write), 5'(p), 5'(r), mdio_wdata};
                    lg_phy[idx]  = p;
                    lg_reg[idx]  = r;
                    lg_treq[idx] = cyc;
                end
                repeat (LAT) @(negedge clk);
                case (r)
                    0:       mdio_rdata = ct[p];
                    1:       mdio_rdata = st[p];
                    4:       mdio_rdata = ad[p];
                    default: mdio_rdata = 16'hFFFF;
                endcase
                mdio_done = 1'b1;
                if (idx < LOGMAX) lg_tdone[idx] = cyc;
                lg_n = lg_n + 1;
                @(negedge clk);
                mdio_done = 1'b0;
            end
        end
    end

    task automatic push(input int w, input int p, input int r, input logic [15:0] d);
        ex_key[ex_n] = {w, 5'(p), 5'(r), d};
        ex_n++;
    endtask

    task automatic clear_phys();
        for (int i = 0; i < 32; i++) begin
            st[i] = 16'hFFFF;
            ct[i] = 16'h0000;
            ad[i] = 16'h0000;
        end
    endtask

    // reference built from the requirement text
    task automatic build_exp(input logic forced, input logic fd, input logic sp,
                             input logic [15:0] cadv);
        int n;
        ex_n = 0;
        n = 0;
        for (int i = 0; i < SLOTS; i++) ex_tab[i] = 0;
        for (int k = 0; k < 32; k++) begin
            int a;
            logic [15:0] s, c, v, pick, nc;
            bit ok, flip;
            a = (k == 31) ? 0 : k + 1;
            push(0, a, 1, 16'h0);
            s  = st[a];
            ok = ((s & 16'h8301) == 16'h8001) || (s[9] == 1'b0 && (s & 16'h7800) != 0);
            if (ok) begin
                ex_tab[n] = a;
                n++;
                push(0, a, 0, 16'h0);
                push(0, a, 4, 16'h0);
                c = ct[a];
                v = ad[a];
                if (v[8:5] == 4'h0) v = ((s >> 6) & 16'h03E0) | 16'h0001;
                pick = (cadv != 0) ? cadv : v;
                if (pick != v) push(1, a, 4, pick);
                nc = c;
                flip = 1'b0;
                if (!forced) begin
                    nc[12] = 1'b1;
                    if (!c[12]) begin nc[9] = 1'b1; flip = 1'b1; end
                end else begin
                    nc[12] = 1'b0;
                    flip = c[12];
                end
                nc[15] = 0; nc[14] = 0; nc[11] = 0; nc[10] = 0; nc[7] = 0;
                nc[8]  = fd;
                nc[13] = sp;
                if (nc != c) begin
                    push(1, a, 0, nc);
                    if (flip) push(1, a, 0, nc);
                end
                if (n == SLOTS) break;
            end
        end
        ex_cnt = n;
        if (n == 0) ex_tab[0] = 1;
    endtask

    task automatic run_case(input string tag, input logic forced, input logic fd,
                            input logic sp, input logic [15:0] cadv);
        int waited, seen;
        build_exp(forced, fd, sp, cadv);
        rst = 1'b1;
        cfg_forced = forced; cfg_full_duplex = fd; cfg_speed100 = sp; cfg_adv = cadv;
        repeat (3) @(negedge clk);
        // reset state (R11/R3)
        chk(!scan_done && !mdio_req && phy_count == 0 && phy_table == '0, "R11",
            {tag, " reset state"}, {scan_done, mdio_req, phy_count}, 0);
        rst = 1'b0;
        waited = 0;
        while (!scan_done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(scan_done, "R11", {tag, " scan finished"}, scan_done, 1);
        seen = lg_n;
        repeat (20) @(negedge clk);
        // R11: done stays set and nothing else is requested
        chk(scan_done && lg_n == seen && !mdio_req, "R11", {tag, " quiet after done"}, lg_n, seen);
        // R1/R2/R5/R6/R7/R8/R9/R10: access sequence
        chk(lg_n == ex_n, tag, "access count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++)
            chk(lg_key[i] == ex_key[i], tag, $sformatf("access %0d", i), lg_key[i], ex_key[i]);
        // R10: gap between doubled control writes
        for (int i = 1; i < lg_n && i < LOGMAX; i++)
            if (lg_reg[i] == 0 && lg_reg[i-1] == 0 && lg_phy[i] == lg_phy[i-1] &&
                lg_key[i] == lg_key[i-1])
                chk(lg_treq[i] - lg_tdone[i-1] >= GAP, "R10", {tag, " write gap"},
                    lg_treq[i] - lg_tdone[i-1], GAP);
        // R3/R4: table and count
        chk(int'(phy_count) == ex_cnt, "R3", {tag, " count"}, phy_count, ex_cnt);
        for (int i = 0; i < SLOTS; i++)
            chk(int'(phy_table[i*5 +: 5]) == ex_tab[i], (ex_cnt == 0) ? "R4" : "R3",
                $sformatf("%s entry %0d", tag, i), phy_table[i*5 +: 5], ex_tab[i]);
    endtask

    task automatic scen_auto_mixed();
        clear_phys();
        st[5] = 16'h7809; ct[5] = 16'h0000; ad[5] = 16'h0000;  // fallback adv, AN off
        st[0] = 16'h8001; ct[0] = 16'h1000; ad[0] = 16'h01E1;  // accepted via first test
        st[7] = 16'h7A09;                                        // bit 9 set: rejected
        st[9] = 16'h0000;                                        // rejected
        run_case("R1 R2 R5 R7 R9", 1'b0, 1'b1, 1'b0, 16'h0000);
    endtask

    task automatic scen_forced_override();
        clear_phys();
        st[3] = 16'h7809; ct[3] = 16'h3100; ad[3] = 16'h01E1;  // AN on -> off, twice
        st[6] = 16'h7809; ct[6] = 16'h0000; ad[6] = 16'h01E1;  // single write
        st[8] = 16'h7809; ct[8] = 16'h2000; ad[8] = 16'h0061;  // nothing to write
        run_case("R6 R8 R10", 1'b1, 1'b0, 1'b1, 16'h0061);
    endtask

    task automatic scen_table_full();
        clear_phys();
        for (int i = 2; i <= 12; i += 2) begin
            st[i] = 16'h7809; ct[i] = 16'h1000; ad[i] = 16'h01E1;
        end
        run_case("R1 R3", 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic scen_auto_restart_kept();
        clear_phys();
        st[17] = 16'h8001; ct[17] = 16'hC680; ad[17] = 16'h0001; // drop-mask bits set
        st[31] = 16'h7809; ct[31] = 16'h1000; ad[31] = 16'h01E1;
        run_case("R5 R7 R9 R10", 1'b0, 1'b0, 1'b1, 16'h0000);
    endtask

    task automatic scen_none();
        clear_phys();
        st[4] = 16'h8301;
        run_case("R4 R2", 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    initial begin
        fork
            begin
                scen_auto_mixed();
                scen_forced_override();
                scen_table_full();
                scen_auto_restart_kept();
                scen_none();
            end
            begin
                repeat (150000) @(negedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule